// File: doc/BRIEF.md
# Dual Strobed Decoder / Demultiplexer

This block holds two four-way demultiplexer sections that share one binary select. Each section has its own active-low strobe and its own data input, and each drives four active-low outputs. The two data inputs have opposite polarity. Section one routes its data inverted, so an asserted (high) data bit pulls the selected output low. Section two routes its data true, so a low data bit pulls the selected output low.

Because of this asymmetry, the two sections can be joined without extra gates. Tie the two strobes into one enable and the two data pins into one line, and that line becomes a third address bit. The result is an eight-way decoder, or a one-to-eight demultiplexer when the enable carries the data. A small wrapper, `dual_dmx_oct`, provides that joined form with a single eight-bit active-low output bus.

The logic is purely combinational: no clock, no state. Every output follows its inputs within the same evaluation.

Top module: `dual_dmx`

## Requirements
- R1: The select `sel_i` is a shared binary index, bit 1 most significant. In each section, output bit `sel_i` is the only output that may go low.
- R2: When strobe 2 is low and `data2_ni` is low, `y2_no[sel_i]` is low and the other three section-2 outputs are high.
- R3: When `strobe1_ni` is high, all four bits of `y1_no` are high, whatever the select and data inputs are.
- R4: When `strobe2_ni` is high, all four bits of `y2_no` are high, whatever the select and data inputs are.
- R5: When `data1_i` is low, all of `y1_no` stays high. When strobe 1 is low and `data1_i` is high, only `y1_no[sel_i]` is low.
- R6: When `data2_ni` is high, all of `y2_no` stays high.
- R7: In the joined wrapper, `code_i` is a 3-bit address with bit 2 driving both data pins. Output bit `y_no[code_i]` goes low, with `y_no[3:0]` taken from section 2 and `y_no[7:4]` taken from section 1.
- R8: In the joined wrapper, exactly one output is low while `strobe_ni` is low, and all eight are high while it is high.
- R9: The outputs are a pure function of the present inputs and settle in the same evaluation as an input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 2 | Shared binary select, bit 1 is MSB |
| strobe1_ni | input | 1 | Section 1 enable, active low |
| strobe2_ni | input | 1 | Section 2 enable, active low |
| data1_i | input | 1 | Section 1 data, active high |
| data2_ni | input | 1 | Section 2 data, active low |
| y1_no | output | 4 | Section 1 outputs, active low |
| y2_no | output | 4 | Section 2 outputs, active low |

## Verification
The block holds no state. A wrong polarity, a swapped select bit or a strobe miswired across sections would therefore show at the outputs in the very evaluation that applies the offending input. It would appear as a wrong bit low, a second bit low, or a bit low that should be high. The bench covers all 64 combinations of select, strobes and data, plus all 16 combinations of the joined wrapper. It checks each one half a clock after applying it, so any such fault appears on the first vector that exercises it.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } data_pol_e;
endpackage

// File: rtl/dmx_sel_dec.sv
module dmx_sel_dec #(
  parameter int SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_OUT-1:0] hot_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_hot
    assign hot_o[i] = (sel_i == SEL_W'(i));
  end

  always_comb begin
    assert_one_hot_R1: assert ($countones(hot_o) == 1);
  end
endmodule

// File: rtl/dmx_section.sv
module dmx_section
  import dmx_pkg::*;
#(
  parameter int        SEL_W = 2,
  parameter data_pol_e POL   = POL_ACT_HIGH,
  localparam int       N_OUT = 1 << SEL_W
) (
  input  logic [N_OUT-1:0] hot_i,
  input  logic             strobe_ni,
  input  logic             data_i,
  output logic [N_OUT-1:0] y_no
);
  logic data_act;
  logic sec_act;

  if (POL == POL_ACT_HIGH) begin : g_pol_hi
    assign data_act = data_i;
  end else begin : g_pol_lo
    assign data_act = ~data_i;
  end

  assign sec_act = ~strobe_ni & data_act;
  assign y_no    = ~(hot_i & {N_OUT{sec_act}});

  always_comb begin
    if (strobe_ni) assert_strobe_off_R3: assert (&y_no);
    assert_single_low_R1: assert ($countones(~y_no) <= 1);
    if (!strobe_ni && data_act) assert_routes_R5: assert ((~y_no) == hot_i);
  end
endmodule

// File: rtl/dual_dmx_oct.sv
module dual_dmx_oct #(
  parameter int  SEL_W  = 2,
  localparam int CODE_W = SEL_W + 1,
  localparam int N_OUT  = 1 << CODE_W,
  localparam int HALF   = N_OUT / 2
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              strobe_ni,
  output logic [N_OUT-1:0]  y_no
);
  logic [HALF-1:0] hi_n;
  logic [HALF-1:0] lo_n;

  dual_dmx #(.SEL_W(SEL_W)) u_pair (
    .sel_i      (code_i[SEL_W-1:0]),
    .strobe1_ni (strobe_ni),
    .strobe2_ni (strobe_ni),
    .data1_i    (code_i[CODE_W-1]),
    .data2_ni   (code_i[CODE_W-1]),
    .y1_no      (hi_n),
    .y2_no      (lo_n)
  );

  assign y_no = {hi_n, lo_n};

  always_comb begin
    if (!strobe_ni) assert_exactly_one_R8: assert ($onehot(~y_no));
    else            assert_all_off_R8: assert (&y_no);
  end
endmodule

// File: rtl/dual_dmx.sv
module dual_dmx
  import dmx_pkg::*;
#(
  parameter int  SEL_W = 2,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             strobe1_ni,
  input  logic             strobe2_ni,
  input  logic             data1_i,
  input  logic             data2_ni,
  output logic [N_OUT-1:0] y1_no,
  output logic [N_OUT-1:0] y2_no
);
  logic [N_OUT-1:0] hot;

  dmx_sel_dec #(.SEL_W(SEL_W)) u_dec (
    .sel_i (sel_i),
    .hot_o (hot)
  );

  dmx_section #(.SEL_W(SEL_W), .POL(POL_ACT_HIGH)) u_sec1 (
    .hot_i     (hot),
    .strobe_ni (strobe1_ni),
    .data_i    (data1_i),
    .y_no      (y1_no)
  );

  dmx_section #(.SEL_W(SEL_W), .POL(POL_ACT_LOW)) u_sec2 (
    .hot_i     (hot),
    .strobe_ni (strobe2_ni),
    .data_i    (data2_ni),
    .y_no      (y2_no)
  );

  // both sections decode the same select, so two active lows share an index
  always_comb begin
    if (!(&y1_no) && !(&y2_no)) assert_shared_sel_R1: assert (y1_no == y2_no);
    if (strobe2_ni) assert_strobe2_off_R4: assert (&y2_no);
    if (data2_ni)   assert_data2_idle_R6: assert (&y2_no);
    if (!data1_i)   assert_data1_idle_R5: assert (&y1_no);
  end
endmodule

// File: tb/tb_dual_dmx.sv
module tb_dual_dmx;
  localparam int SEL_W = 2;

  typedef struct {
    logic [3:0] y1;
    logic [3:0] y2;
    logic [7:0] y8;
    string      tag1;
    string      tag2;
    string      tag8;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [1:0] sel_i = '0;
  logic       strobe1_ni = 1'b1, strobe2_ni = 1'b1, data1_i = 1'b0, data2_ni = 1'b1;
  logic [3:0] y1_no, y2_no;
  logic [2:0] code_i = '0;
  logic       g_ni = 1'b1;
  logic [7:0] y8_no;

  dual_dmx #(.SEL_W(SEL_W)) dut (
    .sel_i, .strobe1_ni, .strobe2_ni, .data1_i, .data2_ni, .y1_no, .y2_no
  );

  dual_dmx_oct #(.SEL_W(SEL_W)) oct (
    .code_i, .strobe_ni(g_ni), .y_no(y8_no)
  );

  int   n_run = 0, n_fail = 0;
  exp_t q[$];
  bit   drv_done = 1'b0;

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply at posedge, push expectation
  task automatic drive(logic [1:0] s, logic g1, logic g2, logic d1, logic d2n,
                       logic [2:0] c, logic g);
    exp_t e;
    @(posedge clk);
    sel_i = s; strobe1_ni = g1; strobe2_ni = g2; data1_i = d1; data2_ni = d2n;
    code_i = c; g_ni = g;
    e.y1 = 4'hF;
    if (!g1 && d1) e.y1[s] = 1'b0;
    e.y2 = 4'hF;
    if (!g2 && !d2n) e.y2[s] = 1'b0;
    e.y8 = 8'hFF;
    if (!g) e.y8[c] = 1'b0;
    e.tag1 = g1 ? "R3" : (!d1 ? "R5" : "R1");
    e.tag2 = g2 ? "R4" : (d2n ? "R6" : "R2");
    e.tag8 = g ? "R8" : "R7";
    q.push_back(e);
  endtask

  // monitor: same-cycle response, sampled half a period later (R9)
  initial begin
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check8(e.tag1, {4'h0, y1_no}, {4'h0, e.y1});
        check8(e.tag2, {4'h0, y2_no}, {4'h0, e.y2});
        check8(e.tag8, y8_no, e.y8);
        n_run++;
        if ($countones(~y8_no) != (e.y8 == 8'hFF ? 0 : 1)) begin
          n_fail++;
          $display("FAIL R8: low count %0d expected %0d", $countones(~y8_no),
                   (e.y8 == 8'hFF ? 0 : 1));
        end
      end else if (drv_done) break;
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // reset state: strobes inactive, every output high (R3, R4, R8)
    check8("R3", {4'h0, y1_no}, 8'h0F);
    check8("R4", {4'h0, y2_no}, 8'h0F);
    check8("R8", y8_no, 8'hFF);
    rst_ni = 1'b1;
    for (int v = 0; v < 64; v++) begin
      automatic logic [5:0] b = 6'(v);
      automatic logic [3:0] t = 4'(v & 15);
      drive(b[1:0], b[2], b[3], b[4], b[5], t[2:0], t[3]);
    end
    // tied-mode sweep with enable low throughout (R7)
    for (int c = 0; c < 8; c++) drive(2'(c), 1'b0, 1'b0, 1'b1, 1'b0, 3'(c), 1'b0);
    drv_done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule